// File: doc/BRIEF.md
# Two-channel timer register window

This block fronts a pair of timer channels on a simple word-wide peripheral bus. It decodes a 4 KB window: the lowest 64 bytes hold two 32-byte channel slots, and each access that lands in a slot becomes a request to that channel with the offset inside the slot. The channels themselves sit outside this block. They receive the request, write enable, write data and offset, and return their read data and interrupt level.

A word at the top of the window returns fixed identification bytes. Two integration-test words and every other location read as zero, and writes to them go nowhere. Read data is registered and comes with a one-cycle valid strobe. The channels' interrupt levels are merged onto one line. Each channel gets its own tick-enable, so the two can count at different rates.

Top module: `dual_timer_window`

## Requirements
- R1: A request with address 0x000–0x01F asserts only `ch_req_o[0]`, in the same cycle, with `ch_off_o` equal to address bits [4:0].
- R2: A request with address 0x020–0x03F asserts only `ch_req_o[1]`, in the same cycle, with `ch_off_o` equal to the address minus 0x020.
- R3: A request with address 0x040 or above asserts no channel request. A write there changes no channel state.
- R4: Reads of the words at 0xFE0, 0xFE4, …, 0xFFC return 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order, zero-extended to 32 bits.
- R5: Reads of the integration-test words 0xF00 and 0xF04 return zero.
- R6: Reads of any other address at or above 0x040 return zero.
- R7: `irq_o` is high whenever either channel interrupt input is high, in the same cycle.
- R8: A read request (`req_i` high, `we_i` low) raises `rvalid_o` in the next cycle only. `rdata_o` then holds the value selected in the request cycle, which for a channel slot is that channel's read data. Writes never raise `rvalid_o`.
- R9: `ch_tick_o[k]` follows `tick_i[k]` for each channel, independently of the other channel.
- R10: While reset is asserted and after it is released, `rvalid_o` is low and `rdata_o` is zero until the first read.
- R11: `ch_we_o` and `ch_wdata_o` carry `we_i` and `wdata_i` to the selected channel in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one word |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| tick_i | input | 2 | Per-channel tick enable |
| ch_tick_o | output | 2 | Tick enable to each channel |
| ch_req_o | output | 2 | Request to channel 0 / 1 |
| ch_we_o | output | 1 | Write enable to channels |
| ch_off_o | output | 5 | Byte offset within the channel slot |
| ch_wdata_o | output | 32 | Write data to channels |
| ch_rdata_i | input | 64 | Channel read data, channel k in bits [32k+31:32k] |
| ch_irq_i | input | 2 | Channel interrupt levels |
| irq_o | output | 1 | Merged interrupt |

## Verification
The assertions assume that every access is a full word, that a channel returns its read data combinationally from the offset in the request cycle, and that `we_i` and `addr_i` are meaningful only while `req_i` is high. The stimulus drives each request for exactly one cycle on the falling edge. The bench's channel models answer from `ch_off_o` at once, and only addresses that are multiples of four are used. Interrupt and tick inputs are changed only away from the rising edge, so the combinational paths can be sampled within the same cycle.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  typedef enum logic [1:0] {
    RG_CHAN  = 2'd0,
    RG_ID    = 2'd1,
    RG_ITEST = 2'd2,
    RG_NONE  = 2'd3
  } region_e;

  localparam int ID_CNT = 8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtw_decode.sv
module dtw_decode
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_CH   = 2,
  parameter int OFF_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [N_CH-1:0]   ch_sel_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [2:0]        id_idx_o
);
  localparam int SLOT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] WIN_TOP  = ADDR_W'((1 << ADDR_W) - 1);
  localparam logic [ADDR_W-1:0] ID_BASE  = ADDR_W'((1 << ADDR_W) - 4 * ID_CNT);
  localparam logic [ADDR_W-1:0] IT_BASE  = ADDR_W'((1 << ADDR_W) - 256);

  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] word_addr;

  assign slot      = addr_i[ADDR_W-1:OFF_W];
  assign word_addr = {addr_i[ADDR_W-1:2], 2'b00};
  assign off_o     = addr_i[OFF_W-1:0];
  assign id_idx_o  = addr_i[4:2];

  for (genvar k = 0; k < N_CH; k++) begin : g_sel
    assign ch_sel_o[k] = (slot == SLOT_W'(k));
  end

  always_comb begin
    if (|ch_sel_o)
      region_o = RG_CHAN;
    else if (word_addr >= ID_BASE && word_addr <= WIN_TOP)
      region_o = RG_ID;
    else if (word_addr == IT_BASE || word_addr == IT_BASE + ADDR_W'(4))
      region_o = RG_ITEST;
    else
      region_o = RG_NONE;
  end
endmodule

// File: rtl/dtw_rd_stage.sv
module dtw_rd_stage
  import dtw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_CH   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  region_e                region_i,
  input  logic [N_CH-1:0]        ch_sel_i,
  input  logic [2:0]             id_idx_i,
  input  logic [N_CH*DATA_W-1:0] ch_rdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rvalid_o
);
  logic [DATA_W-1:0] part [N_CH+1];
  logic [DATA_W-1:0] nxt;

  assign part[0] = '0;
  for (genvar k = 0; k < N_CH; k++) begin : g_mux
    assign part[k+1] = part[k] |
      (ch_sel_i[k] ? ch_rdata_i[k*DATA_W +: DATA_W] : '0);
  end

  always_comb begin
    case (region_i)
      RG_CHAN: nxt = part[N_CH];
      RG_ID:   nxt = DATA_W'(id_byte(id_idx_i));
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= nxt;
    end
  end
endmodule

// File: rtl/dtw_irq_merge.sv
module dtw_irq_merge #(
  parameter int N_CH = 2
) (
  input  logic [N_CH-1:0] irq_i,
  output logic            irq_o
);
  logic [N_CH:0] acc;
  assign acc[0] = 1'b0;
  for (genvar k = 0; k < N_CH; k++) begin : g_or
    assign acc[k+1] = acc[k] | irq_i[k];
  end
  assign irq_o = acc[N_CH];
endmodule

// File: rtl/dual_timer_window.sv
module dual_timer_window
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_CH   = 2,
  parameter int OFF_W  = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rvalid_o,
  input  logic [N_CH-1:0]        tick_i,
  output logic [N_CH-1:0]        ch_tick_o,
  output logic [N_CH-1:0]        ch_req_o,
  output logic                   ch_we_o,
  output logic [OFF_W-1:0]       ch_off_o,
  output logic [DATA_W-1:0]      ch_wdata_o,
  input  logic [N_CH*DATA_W-1:0] ch_rdata_i,
  input  logic [N_CH-1:0]        ch_irq_i,
  output logic                   irq_o
);
  region_e         region;
  logic [N_CH-1:0] ch_sel;
  logic [2:0]      id_idx;

  dtw_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH), .OFF_W(OFF_W)) u_dec (
    .addr_i   (addr_i),
    .region_o (region),
    .ch_sel_o (ch_sel),
    .off_o    (ch_off_o),
    .id_idx_o (id_idx)
  );

  assign ch_req_o   = req_i ? ch_sel : '0;
  assign ch_we_o    = we_i;
  assign ch_wdata_o = wdata_i;
  assign ch_tick_o  = tick_i;

  dtw_rd_stage #(.DATA_W(DATA_W), .N_CH(N_CH)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (req_i & ~we_i),
    .region_i   (region),
    .ch_sel_i   (ch_sel),
    .id_idx_i   (id_idx),
    .ch_rdata_i (ch_rdata_i),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  dtw_irq_merge #(.N_CH(N_CH)) u_irq (
    .irq_i (ch_irq_i),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/dual_timer_window_chk.sv
module dual_timer_window_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_CH   = 2,
  parameter int OFF_W  = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_i,
  input logic                   we_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [DATA_W-1:0]      wdata_i,
  input logic [DATA_W-1:0]      rdata_o,
  input logic                   rvalid_o,
  input logic [N_CH-1:0]        tick_i,
  input logic [N_CH-1:0]        ch_tick_o,
  input logic [N_CH-1:0]        ch_req_o,
  input logic                   ch_we_o,
  input logic [OFF_W-1:0]       ch_off_o,
  input logic [DATA_W-1:0]      ch_wdata_o,
  input logic [N_CH*DATA_W-1:0] ch_rdata_i,
  input logic [N_CH-1:0]        ch_irq_i,
  input logic                   irq_o
);
  assert_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_req_o));

  assert_ch0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i < 12'h020) |-> (ch_req_o == 2'b01 && ch_off_o == addr_i[4:0]));

  assert_ch1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i >= 12'h020 && addr_i < 12'h040)
      |-> (ch_req_o == 2'b10 && ch_off_o == 5'(addr_i - 12'h020)));

  assert_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i >= 12'h040) |-> (ch_req_o == '0));

  assert_id_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 12'hFE0) |=> (rdata_o == 32'h04));

  assert_itest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 12'hF04) |=> (rdata_o == '0));

  assert_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|ch_irq_i));

  assert_rvalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_norvalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  assert_chdata_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i < 12'h020) |=> (rdata_o == $past(ch_rdata_i[DATA_W-1:0])));

  assert_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_tick_o == tick_i);

  assert_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_req_o) |-> (ch_we_o == we_i && ch_wdata_o == wdata_i));
endmodule

bind dual_timer_window dual_timer_window_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/dual_timer_window_test.sv
module dual_timer_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [1:0]  tick = '0, ch_tick, ch_req, ch_irq = '0;
  logic        ch_we, irq;
  logic [4:0]  ch_off;
  logic [31:0] ch_wdata;
  logic [63:0] ch_rdata;

  int total = 0, bad = 0;
  logic [31:0] mdl [2][8];

  always #5 clk = ~clk;

  dual_timer_window uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .tick_i(tick),
    .ch_tick_o(ch_tick), .ch_req_o(ch_req), .ch_we_o(ch_we), .ch_off_o(ch_off),
    .ch_wdata_o(ch_wdata), .ch_rdata_i(ch_rdata), .ch_irq_i(ch_irq), .irq_o(irq)
  );

  // channel models: combinational read, write on clock edge
  assign ch_rdata = {mdl[1][ch_off[4:2]], mdl[0][ch_off[4:2]]};
  initial for (int c = 0; c < 2; c++) for (int w = 0; w < 8; w++) mdl[c][w] = '0;
  always @(posedge clk)
    for (int c = 0; c < 2; c++)
      if (ch_req[c] && ch_we) mdl[c][ch_off[4:2]] <= ch_wdata;

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'h1111_1111, 32'h0},
    '{1'b1, 12'h01C, 32'h2222_0007, 32'h0},
    '{1'b1, 12'h020, 32'h3333_3333, 32'h0},
    '{1'b1, 12'h03C, 32'h0000_4444, 32'h0},
    '{1'b1, 12'h040, 32'hDEAD_BEEF, 32'h0},
    '{1'b1, 12'hFE0, 32'h0000_0055, 32'h0},
    '{0, 12'h000, 32'h0, 32'h1111_1111},
    '{0, 12'h01C, 32'h0, 32'h2222_0007},
    '{0, 12'h020, 32'h0, 32'h3333_3333},
    '{0, 12'h03C, 32'h0, 32'h0000_4444},
    '{0, 12'h040, 32'h0, 32'h0},
    '{0, 12'hFE0, 32'h0, 32'h04},
    '{0, 12'hFE4, 32'h0, 32'h18},
    '{0, 12'hFE8, 32'h0, 32'h14},
    '{0, 12'hFEC, 32'h0, 32'h00},
    '{0, 12'hFF0, 32'h0, 32'h0D},
    '{0, 12'hFF4, 32'h0, 32'hF0},
    '{0, 12'hFF8, 32'h0, 32'h05},
    '{0, 12'hFFC, 32'h0, 32'hB1},
    '{0, 12'hF00, 32'h0, 32'h0},
    '{0, 12'hF04, 32'h0, 32'h0},
    '{0, 12'h800, 32'h0, 32'h0}
  };

  function automatic string tag_of(input logic [11:0] a);
    if (a < 12'h020) return "R1";
    if (a < 12'h040) return "R2";
    if (a >= 12'hFE0) return "R4";
    if (a == 12'hF00 || a == 12'hF04) return "R5";
    return "R6";
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    check("R10 rvalid in reset", 64'(rvalid), 64'd0);
    check("R10 rdata in reset", 64'(rdata), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R10 rvalid after reset", 64'(rvalid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req = 1'b1; we = VECS[i].wr; addr = VECS[i].a; wdata = VECS[i].d;
      #1;
      if (VECS[i].a < 12'h020)
        check("R1 ch_req", 64'({ch_req, ch_off}), 64'({2'b01, VECS[i].a[4:0]}));
      else if (VECS[i].a < 12'h040)
        check("R2 ch_req", 64'({ch_req, ch_off}), 64'({2'b10, 5'(VECS[i].a - 12'h020)}));
      else
        check("R3 no ch_req", 64'(ch_req), 64'd0);
      if (VECS[i].wr && VECS[i].a < 12'h040)
        check("R11 we/wdata", 64'({ch_we, ch_wdata}), 64'({1'b1, VECS[i].d}));
      @(negedge clk);
      req = 1'b0;
      if (VECS[i].wr)
        check("R8 no rvalid on write", 64'(rvalid), 64'd0);
      else begin
        check("R8 rvalid", 64'(rvalid), 64'd1);
        check(tag_of(VECS[i].a), 64'(rdata), 64'(VECS[i].exp));
      end
    end

    // R3: ignored writes left channel word 0 of each channel untouched
    check("R3 ch0 word0", 64'(mdl[0][0]), 64'h1111_1111);
    check("R3 ch1 word0", 64'(mdl[1][0]), 64'h3333_3333);

    // R8: rvalid drops in the cycle after a single read
    @(negedge clk);
    check("R8 rvalid single cycle", 64'(rvalid), 64'd0);
    check("R8 rdata held", 64'(rdata), 64'd0);

    // R7: every interrupt combination
    for (int p = 0; p < 4; p++) begin
      @(negedge clk) ch_irq = 2'(p);
      #1 check("R7 irq merge", 64'(irq), 64'(p != 0));
    end

    // R9: ticks pass independently
    for (int p = 0; p < 4; p++) begin
      @(negedge clk) tick = 2'(p);
      #1 check("R9 tick route", 64'(ch_tick), 64'(p));
    end

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule